// File: doc/BRIEF.md
# Register Front End with Interrupt Merging

This block is the 32-bit register window of a small teaching peripheral. It decodes single-cycle reads and writes on a simple memory-mapped bus. It holds a fixed identification word, an inverting scratch word, a status word and a pending-interrupt word. All pending bits are merged onto one level-sensitive interrupt line.

The compute unit and the DMA engine are separate blocks. The compute unit supplies a busy level and a done pulse. The DMA engine supplies a done pulse. Any access at offset 0x80 or above is forwarded to the DMA engine through a side port. Read data is combinational and valid in the cycle that `rd_i` is high. A write takes effect at the clock edge where `wr_i` is sampled high.

Top module: `mmio_irq_unit`

## Requirements
- R1: A 4-byte read at offset 0x00 returns 0x010000ED.
- R2: A 4-byte write at offset 0x04 stores the bitwise inverse of bits 31:0 of the write data, and a later read at 0x04 returns that stored word. The stored word is zero after reset.
- R3: Offset 0x20 reads as follows: bit 0 is the live level of `fact_busy_i`, bit 7 is an enable that software writes, and all other bits are zero. A write there changes only bit 7. The enable is zero after reset.
- R4: Offset 0x24 returns the pending word. A `fact_done_i` pulse sets bit 0, but only while the enable (bit 7 of 0x20) is set. A `dma_done_i` pulse sets bit 8.
- R5: A 4-byte write at offset 0x60 ORs the write data into the pending word. A 4-byte write at offset 0x64 clears every pending bit that is set in the write data.
- R6: `irq_o` is high in the cycle after the pending word becomes nonzero. It is low in the cycle after the pending word becomes zero. It is low after reset.
- R7: Any read whose size is not 4 bytes returns 0xFFFFFFFF.
- R8: A write below offset 0x80 whose size is not 4 bytes changes no register.
- R9: At offsets 0x80 and above, a write of 4 or 8 bytes raises `ext_wr_o` in the same cycle, and a write of any other size does not. A 4-byte read there returns `ext_rdata_i`.
- R10: If a hardware raise and a software clear of the same bit fall in the same cycle, the bit ends up set.
- R11: Below 0x80, a 4-byte read of an unmapped offset returns zero, and a write to such an offset changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 20 | Byte offset of the access |
| wdata_i | input | 64 | Write data; registers use bits 31:0 |
| size_i | input | 4 | Access size in bytes |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| rdata_o | output | 32 | Read data, combinational |
| fact_busy_i | input | 1 | Compute unit busy level |
| fact_done_i | input | 1 | Compute-done pulse |
| dma_done_i | input | 1 | DMA-done raise pulse |
| ext_wr_o | output | 1 | Accepted write at offset 0x80 or above |
| ext_addr_o | output | 20 | Offset forwarded to the DMA engine |
| ext_wdata_o | output | 64 | Write data forwarded to the DMA engine |
| ext_rdata_i | input | 32 | Read data from the DMA engine |
| irq_o | output | 1 | Level interrupt |

## Verification
A corrupt pending bit shows up one cycle later in two places: on `irq_o` and in any 4-byte read of offset 0x24. A stuck enable is visible at once in a read of 0x20. It is also visible one cycle after a compute-done pulse, when the pulse is either missing from the pending word or appears there without permission. A decode or size-filter fault shows in the same cycle. It either changes combinational read data, or it leaves a stray write that the next read of the targeted register exposes.

// File: rtl/mmio_irq_pkg.sv
package mmio_irq_pkg;
  localparam logic [7:0] OFS_ID      = 8'h00;
  localparam logic [7:0] OFS_SCRATCH = 8'h04;
  localparam logic [7:0] OFS_STATUS  = 8'h20;
  localparam logic [7:0] OFS_PEND    = 8'h24;
  localparam logic [7:0] OFS_SET     = 8'h60;
  localparam logic [7:0] OFS_CLR     = 8'h64;
  localparam logic [7:0] OFS_EXT     = 8'h80;

  localparam logic [31:0] ID_WORD = 32'h0100_00ED;

  localparam int unsigned BIT_BUSY = 0;
  localparam int unsigned BIT_EN   = 7;
  localparam int unsigned BIT_FACT = 0;
  localparam int unsigned BIT_DMA  = 8;

  typedef struct packed {
    logic id;
    logic scratch;
    logic status;
    logic pend;
    logic set;
    logic clr;
    logic ext;
  } sel_t;
endpackage

// File: rtl/mmio_decode.sv
module mmio_decode
  import mmio_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned SIZE_W = 4
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic              rd_i,
  input  logic              wr_i,
  output sel_t              rd_sel_o,
  output logic              rd_size_ok_o,
  output sel_t              wr_sel_o
);
  localparam logic [ADDR_W-1:0] EXT_BASE = ADDR_W'(OFS_EXT);

  sel_t hit;
  logic is_ext, size4, size8, wr_ok;

  function automatic logic at(input logic [ADDR_W-1:0] a, input logic [7:0] ofs);
    return a == ADDR_W'(ofs);
  endfunction

  always_comb begin
    is_ext      = addr_i >= EXT_BASE;
    size4       = size_i == SIZE_W'(4);
    size8       = size_i == SIZE_W'(8);
    hit.id      = at(addr_i, OFS_ID);
    hit.scratch = at(addr_i, OFS_SCRATCH);
    hit.status  = at(addr_i, OFS_STATUS);
    hit.pend    = at(addr_i, OFS_PEND);
    hit.set     = at(addr_i, OFS_SET);
    hit.clr     = at(addr_i, OFS_CLR);
    hit.ext     = is_ext;
    // high window takes 8-byte writes too
    wr_ok       = wr_i && (is_ext ? (size4 || size8) : size4);
    wr_sel_o    = wr_ok ? hit : '0;
    rd_sel_o    = rd_i ? hit : '0;
    rd_size_ok_o = size4;
  end
endmodule

// File: rtl/irq_pending.sv
module irq_pending #(
  parameter int unsigned IRQ_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IRQ_W-1:0] sw_set_i,
  input  logic [IRQ_W-1:0] sw_clr_i,
  input  logic [IRQ_W-1:0] hw_set_i,
  output logic [IRQ_W-1:0] pend_o,
  output logic             irq_o
);
  logic [IRQ_W-1:0] pend_d;

  for (genvar b = 0; b < IRQ_W; b++) begin : g_bit
    // raise wins over clear
    assign pend_d[b] = hw_set_i[b] | sw_set_i[b] | (pend_o[b] & ~sw_clr_i[b]);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pend_o[b] <= 1'b0;
      else         pend_o[b] <= pend_d[b];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= |pend_d;
  end
endmodule

// File: rtl/mmio_irq_unit.sv
module mmio_irq_unit
  import mmio_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned BUS_W  = 64,
  parameter int unsigned REG_W  = 32,
  parameter int unsigned SIZE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic              rd_i,
  input  logic              wr_i,
  output logic [REG_W-1:0]  rdata_o,
  input  logic              fact_busy_i,
  input  logic              fact_done_i,
  input  logic              dma_done_i,
  output logic              ext_wr_o,
  output logic [ADDR_W-1:0] ext_addr_o,
  output logic [BUS_W-1:0]  ext_wdata_o,
  input  logic [REG_W-1:0]  ext_rdata_i,
  output logic              irq_o
);
  sel_t rd_sel, wr_sel;
  logic rd_size_ok;
  logic [REG_W-1:0] wdat, scratch_q, pend_q, status_w, hw_set, sw_set, sw_clr;
  logic en_q;

  assign wdat = wdata_i[REG_W-1:0];

  mmio_decode #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_dec (
    .addr_i      (addr_i),
    .size_i      (size_i),
    .rd_i        (rd_i),
    .wr_i        (wr_i),
    .rd_sel_o    (rd_sel),
    .rd_size_ok_o(rd_size_ok),
    .wr_sel_o    (wr_sel)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scratch_q <= '0;
      en_q      <= 1'b0;
    end else begin
      if (wr_sel.scratch) scratch_q <= ~wdat;
      if (wr_sel.status)  en_q      <= wdat[BIT_EN];
    end
  end

  always_comb begin
    hw_set           = '0;
    hw_set[BIT_FACT] = fact_done_i & en_q;
    hw_set[BIT_DMA]  = dma_done_i;
    sw_set           = wr_sel.set ? wdat : '0;
    sw_clr           = wr_sel.clr ? wdat : '0;
    status_w           = '0;
    status_w[BIT_BUSY] = fact_busy_i;
    status_w[BIT_EN]   = en_q;
  end

  irq_pending #(.IRQ_W(REG_W)) u_pend (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sw_set_i(sw_set),
    .sw_clr_i(sw_clr),
    .hw_set_i(hw_set),
    .pend_o  (pend_q),
    .irq_o   (irq_o)
  );

  assign ext_wr_o    = wr_sel.ext;
  assign ext_addr_o  = addr_i;
  assign ext_wdata_o = wdata_i;

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      if (!rd_size_ok)        rdata_o = '1;
      else if (rd_sel.ext)     rdata_o = ext_rdata_i;
      else if (rd_sel.id)      rdata_o = ID_WORD;
      else if (rd_sel.scratch) rdata_o = scratch_q;
      else if (rd_sel.status)  rdata_o = status_w;
      else if (rd_sel.pend)    rdata_o = pend_q;
    end
  end
endmodule

// File: rtl/mmio_irq_chk.sv
module mmio_irq_chk #(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned REG_W  = 32,
  parameter int unsigned SIZE_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic [SIZE_W-1:0] size_i,
  input logic              rd_i,
  input logic              wr_i,
  input logic [REG_W-1:0]  rdata_o,
  input logic [REG_W-1:0]  wdata_lo,
  input logic              fact_busy_i,
  input logic              dma_done_i,
  input logic              ext_wr_o,
  input logic              irq_o,
  input logic [REG_W-1:0]  pend_q,
  input logic [REG_W-1:0]  scratch_q
);
  localparam logic [ADDR_W-1:0] A_ID   = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(8'h20);
  localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(8'h60);
  localparam logic [ADDR_W-1:0] A_EXT  = ADDR_W'(8'h80);

  // R7
  always_comb begin
    if (rst_ni && rd_i && size_i != SIZE_W'(4))
      narrow_rd_chk: assert (rdata_o == '1);
  end

  // R1
  id_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == A_ID && size_i == SIZE_W'(4)) |-> rdata_o == 32'h0100_00ED);

  // R3
  busy_mirror_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == A_STAT && size_i == SIZE_W'(4)) |-> rdata_o[0] == fact_busy_i);

  // R6
  irq_on_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == A_SET && size_i == SIZE_W'(4) && wdata_lo != '0) |=> irq_o);

  // R10
  dma_raise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_done_i |=> (pend_q[8] && irq_o));

  // R9
  ext_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_wr_o |-> (wr_i && addr_i >= A_EXT && (size_i == SIZE_W'(4) || size_i == SIZE_W'(8))));

  // R8
  narrow_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i < A_EXT && size_i != SIZE_W'(4)) |=> $stable(scratch_q));
endmodule

bind mmio_irq_unit mmio_irq_chk #(.ADDR_W(ADDR_W), .REG_W(REG_W), .SIZE_W(SIZE_W)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .addr_i     (addr_i),
  .size_i     (size_i),
  .rd_i       (rd_i),
  .wr_i       (wr_i),
  .rdata_o    (rdata_o),
  .wdata_lo   (wdat),
  .fact_busy_i(fact_busy_i),
  .dma_done_i (dma_done_i),
  .ext_wr_o   (ext_wr_o),
  .irq_o      (irq_o),
  .pend_q     (pend_q),
  .scratch_q  (scratch_q)
);

// File: tb/test_mmio_irq_unit.sv
module test_mmio_irq_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [19:0] addr = '0;
  logic [63:0] wdata = '0;
  logic [3:0]  size = 4'd4;
  logic        rd = 1'b0, wr = 1'b0;
  logic [31:0] rdata;
  logic        busy = 1'b0, fdone = 1'b0, ddone = 1'b0;
  logic        ext_wr;
  logic [19:0] ext_addr;
  logic [63:0] ext_wdata;
  logic [31:0] ext_rdata = 32'hCAFE_0123;
  logic        irq;

  int n_chk = 0, n_fail = 0;
  logic [31:0] r;
  logic        seen;

  always #10 clk = ~clk;

  mmio_irq_unit i_mmio_irq_unit (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .size_i(size),
    .rd_i(rd), .wr_i(wr), .rdata_o(rdata), .fact_busy_i(busy), .fact_done_i(fdone),
    .dma_done_i(ddone), .ext_wr_o(ext_wr), .ext_addr_o(ext_addr),
    .ext_wdata_o(ext_wdata), .ext_rdata_i(ext_rdata), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [19:0] a, input logic [63:0] d, input logic [3:0] s);
    @(negedge clk);
    addr = a; wdata = d; size = s; wr = 1'b1;
    #1 seen = ext_wr;
    @(negedge clk);
    wr = 1'b0; size = 4'd4;
  endtask

  task automatic bus_rd(input logic [19:0] a, input logic [3:0] s, output logic [31:0] d);
    @(negedge clk);
    addr = a; size = s; rd = 1'b1;
    #1 d = rdata;
    rd = 1'b0; size = 4'd4;
  endtask

  task automatic t_reset;
    chk("R6 irq after reset", irq, 0);
    bus_rd(20'h24, 4, r); chk("R6 pend after reset", r, 0);
    bus_rd(20'h04, 4, r); chk("R2 scratch after reset", r, 0);
    bus_rd(20'h20, 4, r); chk("R3 status after reset", r, 0);
  endtask

  task automatic t_id_scratch;
    bus_rd(20'h00, 4, r); chk("R1 id", r, 32'h0100_00ED);
    bus_wr(20'h04, 64'h1234_5678, 4);
    bus_rd(20'h04, 4, r); chk("R2 inverse", r, 32'hEDCB_A987);
  endtask

  task automatic t_status;
    bus_wr(20'h20, 64'hFFFF_FFFF, 4);
    bus_rd(20'h20, 4, r); chk("R3 only enable written", r, 32'h80);
    busy = 1'b1;
    bus_rd(20'h20, 4, r); chk("R3 busy live", r, 32'h81);
    bus_wr(20'h20, 64'h0, 4);
    bus_rd(20'h20, 4, r); chk("R3 enable cleared", r, 32'h01);
    busy = 1'b0;
  endtask

  task automatic t_sources;
    @(negedge clk); fdone = 1'b1; @(negedge clk); fdone = 1'b0;
    bus_rd(20'h24, 4, r); chk("R4 masked compute done", r, 0);
    chk("R6 irq stays low", irq, 0);
    bus_wr(20'h20, 64'h80, 4);
    @(negedge clk); fdone = 1'b1; @(negedge clk); fdone = 1'b0;
    bus_rd(20'h24, 4, r); chk("R4 compute done", r, 32'h1);
    chk("R6 irq high", irq, 1);
    @(negedge clk); ddone = 1'b1; @(negedge clk); ddone = 1'b0;
    bus_rd(20'h24, 4, r); chk("R4 dma done", r, 32'h101);
  endtask

  task automatic t_set_clr;
    bus_wr(20'h64, 64'h1, 4);
    bus_rd(20'h24, 4, r); chk("R5 clear one", r, 32'h100);
    bus_wr(20'h60, 64'h30, 4);
    bus_rd(20'h24, 4, r); chk("R5 set ORs", r, 32'h130);
    bus_wr(20'h64, 64'hFFFF_FFFF, 4);
    bus_rd(20'h24, 4, r); chk("R5 clear all", r, 0);
    chk("R6 irq low", irq, 0);
    bus_wr(20'h60, 64'h8000_0000, 4);
    chk("R6 irq from top bit", irq, 1);
    bus_wr(20'h64, 64'h8000_0000, 4);
  endtask

  task automatic t_race;
    @(negedge clk);
    addr = 20'h64; wdata = 64'h100; size = 4; wr = 1'b1; ddone = 1'b1;
    @(negedge clk);
    wr = 1'b0; ddone = 1'b0;
    bus_rd(20'h24, 4, r); chk("R10 raise beats clear", r, 32'h100);
    chk("R10 irq kept", irq, 1);
    bus_wr(20'h64, 64'h100, 4);
  endtask

  task automatic t_sizes;
    bus_rd(20'h00, 2, r); chk("R7 narrow read", r, 32'hFFFF_FFFF);
    bus_rd(20'h90, 8, r); chk("R7 wide read high", r, 32'hFFFF_FFFF);
    bus_wr(20'h04, 64'h0, 2);
    bus_rd(20'h04, 4, r); chk("R8 narrow write ignored", r, 32'hEDCB_A987);
    bus_wr(20'h60, 64'h1, 1);
    bus_rd(20'h24, 4, r); chk("R8 narrow set ignored", r, 0);
    bus_wr(20'h04, 64'h0, 8);
    bus_rd(20'h04, 4, r); chk("R8 8-byte low write ignored", r, 32'hEDCB_A987);
  endtask

  task automatic t_ext;
    bus_wr(20'h88, 64'h1, 8); chk("R9 8-byte ext write", seen, 1);
    bus_wr(20'h98, 64'h1, 4); chk("R9 4-byte ext write", seen, 1);
    bus_wr(20'h80, 64'h1, 2); chk("R9 2-byte ext dropped", seen, 0);
    bus_wr(20'h04, 64'h1, 4); chk("R9 low write not forwarded", seen, 0);
    bus_rd(20'h90, 4, r); chk("R9 ext read", r, 32'hCAFE_0123);
  endtask

  task automatic t_unmapped;
    bus_rd(20'h40, 4, r); chk("R11 unmapped read", r, 0);
    bus_wr(20'h44, 64'hFFFF_FFFF, 4);
    bus_rd(20'h24, 4, r); chk("R11 pend untouched", r, 0);
    bus_rd(20'h04, 4, r); chk("R11 scratch untouched", r, 32'hFFFF_FFFE);
    bus_rd(20'h20, 4, r); chk("R11 status untouched", r, 32'h80);
  endtask

  initial begin
    #200000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_id_scratch();
    t_status();
    t_sources();
    t_set_clr();
    t_race();
    t_sizes();
    t_ext();
    t_unmapped();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule